// File: doc/BRIEF.md
# SDRAM Device-Side Command Decoder

This block is the command front end of a synchronous DRAM device model. On every rising clock edge it samples the chip select, the three strobes (RAS, CAS, WE), the bank select and the address. It turns them into a one-hot command pulse for the cycle that follows. It also owns the mode register, which holds the CAS latency, burst length, wrap type and write-burst option. Finally it keeps a per-bank table that records which banks are open and at which row.

Decoding depends on that state. A command that the current bank or mode state does not allow is not executed. It raises a one-cycle illegal flag instead and leaves all state untouched. Downstream logic (burst sequencing, data path, refresh timing) consumes the registered command pulse, the latched bank and address, and the mode and bank outputs.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: Commands are decoded from {cs_n, ras_n, cas_n, we_n} sampled at a rising edge. cs_n=1 or 0111 gives NOP, 0011 ACTIVATE, 0101 READ, 0100 WRITE, 0010 PRECHARGE, 0001 REFRESH and 0000 MODE SET. cmd_o bit order is 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH, 6 MODE SET.
- R2: A legal MODE SET loads the mode register from the address field. The burst length field is A[2:0]: 000 gives 1, 001 gives 2, 010 gives 4 and 011 gives 8. A3 selects interleave when 1. The CAS latency field is A[6:4]: 010 gives 2 and 011 gives 3. A9=1 selects single-location writes. Other address and bank bits are ignored.
- R3: A MODE SET whose burst length or CAS latency code is outside those lists raises mode_bad_o and illegal_o for one cycle and leaves the mode register unchanged.
- R4: A MODE SET while any bank is open is illegal and changes nothing.
- R5: An ACTIVATE to an idle bank opens it and stores A[11:0] as its row. An ACTIVATE to an already open bank is illegal.
- R6: A READ or WRITE to an idle bank is illegal and changes no state. To an open bank it is legal, and the command's bank and address are presented on cmd_bank_o and cmd_addr_o.
- R7: A legal READ or WRITE with A10=1 asserts auto_pre_o and leaves that bank idle afterwards. With A10=0 the bank stays open.
- R8: PRECHARGE with A10=0 closes the selected bank, and with A10=1 closes all banks. It is legal even on idle banks.
- R9: REFRESH is legal only when every bank is idle.
- R10: The unassigned code 0110 is illegal. No illegal command changes bank or mode state, and cmd_o is all zero while illegal_o is high.
- R11: Synchronous active-high reset leaves all banks idle, cmd_o and flags zero, and the mode at CAS latency 3, burst length 1, sequential, burst writes.
- R12: All outputs are registered. A command sampled at edge N shows on cmd_o only during the cycle after edge N, and state changes are visible from that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write enable, low active |
| ba | input | BA_W | Bank select |
| addr | input | ADDR_W | Multiplexed row/column/mode address |
| cmd_o | output | 7 | One-hot decoded legal command |
| illegal_o | output | 1 | Command was rejected |
| mode_bad_o | output | 1 | Mode set carried an invalid code |
| auto_pre_o | output | 1 | Read/write with auto precharge |
| cmd_bank_o | output | BA_W | Bank of the sampled command |
| cmd_addr_o | output | ADDR_W | Address of the sampled command |
| bank_open_o | output | 2**BA_W | Per-bank open flag |
| open_rows_o | output | 2**BA_W*ROW_W | Row per bank, bank 0 in the low bits |
| cas_lat_o | output | 2 | Programmed CAS latency (2 or 3) |
| burst_len_o | output | 4 | Programmed burst length (1, 2, 4, 8) |
| wrap_il_o | output | 1 | 1 = interleave wrap |
| single_wr_o | output | 1 | 1 = single-location writes |

## Verification
The bench sweeps all 64 combinations of burst length and latency codes through MODE SET. A decoder that accepted a reserved code would corrupt the latency or length outputs, and one that rejected a legal code would miss a mode change. A long pseudo-random run over all sixteen control codes, all banks and both A10 values is then compared against an arithmetic model of the bank table. This catches a read to a closed bank that slips through or an ACTIVATE that overwrites an open row. It also catches an auto precharge or precharge-all that closes the wrong banks, and a MODE SET or REFRESH accepted with a row open. Directed steps confirm that the command pulse lasts exactly one cycle and that every field reads correctly after reset.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;
  typedef enum logic [2:0] {
    K_NOP = 3'd0,
    K_ACT = 3'd1,
    K_RD  = 3'd2,
    K_WR  = 3'd3,
    K_PRE = 3'd4,
    K_REF = 3'd5,
    K_MRS = 3'd6,
    K_BAD = 3'd7
  } cmd_kind_t;

  localparam int NUM_CMD = 7;
endpackage

// File: rtl/sdram_cmd_classify.sv
module sdram_cmd_classify (
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  output sdram_dec_pkg::cmd_kind_t kind
);
  import sdram_dec_pkg::*;

  always_comb begin
    if (cs_n) begin
      kind = K_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  kind = K_NOP;
        3'b011:  kind = K_ACT;
        3'b101:  kind = K_RD;
        3'b100:  kind = K_WR;
        3'b010:  kind = K_PRE;
        3'b001:  kind = K_REF;
        3'b000:  kind = K_MRS;
        default: kind = K_BAD;
      endcase
    end
  end
endmodule

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [2:0] bl_code,
  input  logic       wrap_bit,
  input  logic [2:0] cl_code,
  input  logic       wb_bit,
  output logic       code_ok,
  output logic [1:0] cl_o,
  output logic [3:0] bl_o,
  output logic       wrap_o,
  output logic       single_o
);
  logic bl_ok, cl_ok;

  always_comb begin
    bl_ok   = (bl_code[2] == 1'b0);
    cl_ok   = (cl_code == 3'd2) || (cl_code == 3'd3);
    code_ok = bl_ok && cl_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cl_o     <= 2'd3;
      bl_o     <= 4'd1;
      wrap_o   <= 1'b0;
      single_o <= 1'b0;
    end else if (load && code_ok) begin
      cl_o     <= cl_code[1:0];
      bl_o     <= 4'd1 << bl_code[1:0];
      wrap_o   <= wrap_bit;
      single_o <= wb_bit;
    end
  end
endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table #(
  parameter int BA_W  = 2,
  parameter int ROW_W = 12,
  localparam int NB   = 1 << BA_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                act_en,
  input  logic                pre_en,
  input  logic                pre_all,
  input  logic                close_en,
  input  logic [BA_W-1:0]     bank,
  input  logic [ROW_W-1:0]    row,
  output logic [NB-1:0]       open_o,
  output logic [NB*ROW_W-1:0] rows_o
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit;
    assign hit = (bank == BA_W'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        open_o[b]               <= 1'b0;
        rows_o[b*ROW_W +: ROW_W] <= '0;
      end else if (act_en && hit) begin
        open_o[b]               <= 1'b1;
        rows_o[b*ROW_W +: ROW_W] <= row;
      end else if ((pre_en && (pre_all || hit)) || (close_en && hit)) begin
        open_o[b] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder #(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 12,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10,
  localparam int NB    = 1 << BA_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic [BA_W-1:0]     ba,
  input  logic [ADDR_W-1:0]   addr,
  output logic [6:0]          cmd_o,
  output logic                illegal_o,
  output logic                mode_bad_o,
  output logic                auto_pre_o,
  output logic [BA_W-1:0]     cmd_bank_o,
  output logic [ADDR_W-1:0]   cmd_addr_o,
  output logic [NB-1:0]       bank_open_o,
  output logic [NB*ROW_W-1:0] open_rows_o,
  output logic [1:0]          cas_lat_o,
  output logic [3:0]          burst_len_o,
  output logic                wrap_il_o,
  output logic                single_wr_o
);
  import sdram_dec_pkg::*;

  cmd_kind_t kind;
  logic      legal, mode_ok, sel_open, any_open, is_rw;

  sdram_cmd_classify u_cls (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .kind(kind)
  );

  always_comb begin
    sel_open = bank_open_o[ba];
    any_open = |bank_open_o;
    is_rw    = (kind == K_RD) || (kind == K_WR);
    case (kind)
      K_NOP, K_PRE: legal = 1'b1;
      K_ACT:        legal = !sel_open;
      K_RD, K_WR:   legal = sel_open;
      K_REF:        legal = !any_open;
      K_MRS:        legal = !any_open && mode_ok;
      default:      legal = 1'b0;
    endcase
  end

  sdram_mode_reg u_mode (
    .clk(clk), .rst(rst),
    .load(kind == K_MRS && legal),
    .bl_code(addr[2:0]), .wrap_bit(addr[3]),
    .cl_code(addr[6:4]), .wb_bit(addr[9]),
    .code_ok(mode_ok),
    .cl_o(cas_lat_o), .bl_o(burst_len_o),
    .wrap_o(wrap_il_o), .single_o(single_wr_o)
  );

  sdram_bank_table #(.BA_W(BA_W), .ROW_W(ROW_W)) u_banks (
    .clk(clk), .rst(rst),
    .act_en(kind == K_ACT && legal),
    .pre_en(kind == K_PRE),
    .pre_all(addr[AP_BIT]),
    .close_en(is_rw && legal && addr[AP_BIT]),
    .bank(ba), .row(addr[ROW_W-1:0]),
    .open_o(bank_open_o), .rows_o(open_rows_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o      <= '0;
      illegal_o  <= 1'b0;
      mode_bad_o <= 1'b0;
      auto_pre_o <= 1'b0;
      cmd_bank_o <= '0;
      cmd_addr_o <= '0;
    end else begin
      cmd_o      <= legal ? (7'd1 << kind) : 7'd0;
      illegal_o  <= !legal;
      mode_bad_o <= (kind == K_MRS) && !mode_ok;
      auto_pre_o <= legal && is_rw && addr[AP_BIT];
      cmd_bank_o <= ba;
      cmd_addr_o <= addr;
    end
  end
endmodule

// File: rtl/sdram_cmd_decoder_chk.sv
module sdram_cmd_decoder_chk #(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10,
  localparam int NB    = 1 << BA_W
) (
  input logic              clk,
  input logic              rst,
  input logic [6:0]        cmd_o,
  input logic              illegal_o,
  input logic [BA_W-1:0]   cmd_bank_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic [NB-1:0]     bank_open_o,
  input logic [1:0]        cas_lat_o,
  input logic [3:0]        burst_len_o,
  input logic              wrap_il_o,
  input logic              single_wr_o
);
  logic [NB-1:0] prev_open;

  always_ff @(posedge clk) begin
    if (rst) prev_open <= '0;
    else     prev_open <= bank_open_o;
  end

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({illegal_o, cmd_o})); // R10
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
    cmd_o[1] |-> (bank_open_o[cmd_bank_o] && !prev_open[cmd_bank_o])); // R5
  AST_RDWR_OPEN: assert property (@(posedge clk) disable iff (rst)
    (cmd_o[2] || cmd_o[3]) |-> prev_open[cmd_bank_o]); // R6
  AST_AUTOPRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    ((cmd_o[2] || cmd_o[3]) && cmd_addr_o[AP_BIT]) |-> !bank_open_o[cmd_bank_o]); // R7
  AST_PREALL: assert property (@(posedge clk) disable iff (rst)
    (cmd_o[4] && cmd_addr_o[AP_BIT]) |-> (bank_open_o == '0)); // R8
  AST_REF_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmd_o[5] |-> (prev_open == '0)); // R9
  AST_MRS_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmd_o[6] |-> (prev_open == '0)); // R4
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !cmd_o[6] |-> $stable({cas_lat_o, burst_len_o, wrap_il_o, single_wr_o})); // R3
  AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (bank_open_o == prev_open)); // R10
  AST_CL_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cas_lat_o == 2'd2) || (cas_lat_o == 2'd3)); // R2
endmodule

bind sdram_cmd_decoder sdram_cmd_decoder_chk #(
  .BA_W(BA_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
) u_chk (
  .clk(clk), .rst(rst), .cmd_o(cmd_o), .illegal_o(illegal_o),
  .cmd_bank_o(cmd_bank_o), .cmd_addr_o(cmd_addr_o),
  .bank_open_o(bank_open_o), .cas_lat_o(cas_lat_o),
  .burst_len_o(burst_len_o), .wrap_il_o(wrap_il_o),
  .single_wr_o(single_wr_o)
);

// File: tb/sdram_cmd_decoder_test.sv
module sdram_cmd_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [6:0]  cmd_o;
  logic        illegal_o, mode_bad_o, auto_pre_o;
  logic [1:0]  cmd_bank_o;
  logic [11:0] cmd_addr_o;
  logic [3:0]  bank_open_o;
  logic [47:0] open_rows_o;
  logic [1:0]  cas_lat_o;
  logic [3:0]  burst_len_o;
  logic        wrap_il_o, single_wr_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic        m_open [4];
  logic [11:0] m_row  [4];
  logic [1:0]  m_cl;
  logic [3:0]  m_bl;
  logic        m_wrap, m_single;

  always #2.5 clk = ~clk;

  sdram_cmd_decoder uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o),
    .illegal_o(illegal_o), .mode_bad_o(mode_bad_o), .auto_pre_o(auto_pre_o),
    .cmd_bank_o(cmd_bank_o), .cmd_addr_o(cmd_addr_o),
    .bank_open_o(bank_open_o), .open_rows_o(open_rows_o),
    .cas_lat_o(cas_lat_o), .burst_len_o(burst_len_o),
    .wrap_il_o(wrap_il_o), .single_wr_o(single_wr_o)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic check_state(string tag);
    chk(tag, "cas_lat", 64'(cas_lat_o), 64'(m_cl));
    chk(tag, "burst_len", 64'(burst_len_o), 64'(m_bl));
    chk(tag, "wrap", 64'(wrap_il_o), 64'(m_wrap));
    chk(tag, "single_wr", 64'(single_wr_o), 64'(m_single));
    for (int b = 0; b < 4; b++) begin
      chk(tag, "bank_open", 64'(bank_open_o[b]), 64'(m_open[b]));
      if (m_open[b]) chk(tag, "row", 64'(open_rows_o[b*12 +: 12]), 64'(m_row[b]));
    end
  endtask

  // kind codes: 0 NOP 1 ACT 2 RD 3 WR 4 PRE 5 REF 6 MRS 7 unassigned
  task automatic step(logic c, logic r, logic a, logic w, logic [1:0] bk, logic [11:0] ad);
    int    kind;
    logic  legal, any, valid;
    string tag;
    any   = m_open[0] | m_open[1] | m_open[2] | m_open[3];
    valid = (ad[2] == 1'b0) && ((ad[6:4] == 3'd2) || (ad[6:4] == 3'd3));
    if (c) kind = 0;
    else case ({r, a, w})
      3'b111: kind = 0; 3'b011: kind = 1; 3'b101: kind = 2; 3'b100: kind = 3;
      3'b010: kind = 4; 3'b001: kind = 5; 3'b000: kind = 6; default: kind = 7;
    endcase
    case (kind)
      0, 4:    legal = 1'b1;
      1:       legal = !m_open[bk];
      2, 3:    legal = m_open[bk];
      5:       legal = !any;
      6:       legal = !any && valid;
      default: legal = 1'b0;
    endcase
    case (kind)
      0: tag = "R1";
      1: tag = "R5";
      2, 3: tag = (legal && ad[10]) ? "R7" : "R6";
      4: tag = "R8";
      5: tag = "R9";
      6: tag = !valid ? "R3" : (any ? "R4" : "R2");
      default: tag = "R10";
    endcase
    if (legal) begin
      if (kind == 1) begin m_open[bk] = 1'b1; m_row[bk] = ad; end
      if (kind == 4) begin
        if (ad[10]) for (int b = 0; b < 4; b++) m_open[b] = 1'b0;
        else m_open[bk] = 1'b0;
      end
      if ((kind == 2 || kind == 3) && ad[10]) m_open[bk] = 1'b0;
      if (kind == 6) begin
        m_cl = ad[5:4]; m_bl = 4'd1 << ad[1:0]; m_wrap = ad[3]; m_single = ad[9];
      end
    end
    cs_n = c; ras_n = r; cas_n = a; we_n = w; ba = bk; addr = ad;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "cmd", 64'(cmd_o), legal ? 64'(7'd1 << kind) : 64'd0);
    chk(tag, "illegal", 64'(illegal_o), 64'(!legal));
    chk(tag, "mode_bad", 64'(mode_bad_o), 64'(kind == 6 && !valid));
    chk(tag, "auto_pre", 64'(auto_pre_o), 64'(legal && (kind == 2 || kind == 3) && ad[10]));
    chk(tag, "cmd_bank", 64'(cmd_bank_o), 64'(bk));
    chk(tag, "cmd_addr", 64'(cmd_addr_o), 64'(ad));
    check_state(tag);
  endtask

  task automatic issue(int kind, logic [1:0] bk, logic [11:0] ad);
    case (kind)
      1: step(0, 0, 1, 1, bk, ad);
      2: step(0, 1, 0, 1, bk, ad);
      3: step(0, 1, 0, 0, bk, ad);
      4: step(0, 0, 1, 0, bk, ad);
      5: step(0, 0, 0, 1, bk, ad);
      6: step(0, 0, 0, 0, bk, ad);
      default: step(1, 1, 1, 1, bk, ad);
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      report();
    end
  end

  initial begin
    for (int b = 0; b < 4; b++) begin m_open[b] = 1'b0; m_row[b] = '0; end
    m_cl = 2'd3; m_bl = 4'd1; m_wrap = 1'b0; m_single = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk("R11", "cmd", 64'(cmd_o), 64'd0);
    chk("R11", "illegal", 64'(illegal_o), 64'd0);
    chk("R11", "mode_bad", 64'(mode_bad_o), 64'd0);
    check_state("R11");

    // R2 / R3: every length and latency code, wrap and write option toggled
    for (int bl = 0; bl < 8; bl++)
      for (int cl = 0; cl < 8; cl++)
        issue(6, 2'(bl), 12'((((bl + cl) & 1) << 9) | (cl << 4) | (((cl >> 1) & 1) << 3) | bl));
    issue(6, 2'd0, 12'h032);

    // R5, R6, R7, R8 directed
    for (int b = 0; b < 4; b++) issue(2, 2'(b), 12'h010);
    for (int b = 0; b < 4; b++) issue(1, 2'(b), 12'(12'h5A0 + b * 12'h111));
    // R12: pulse lasts one cycle, state persists
    issue(0, 2'd0, 12'h000);
    chk("R12", "cmd after deselect", 64'(cmd_o), 64'd1);
    chk("R12", "banks still open", 64'(bank_open_o), 64'hF);
    issue(1, 2'd2, 12'h123);
    issue(5, 2'd0, 12'h000);
    issue(6, 2'd0, 12'h022);
    issue(2, 2'd1, 12'h404);
    issue(3, 2'd3, 12'h008);
    issue(3, 2'd0, 12'h400);
    issue(4, 2'd2, 12'h000);
    issue(4, 2'd0, 12'h400);
    issue(3, 2'd1, 12'h000);
    step(0, 1, 1, 0, 2'd0, 12'h000);
    issue(5, 2'd0, 12'h000);

    // randomized sweep over all control codes, banks and A10
    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  ctl;
      logic [11:0] ad;
      ctl = 4'($urandom_range(0, 15));
      ad  = 12'($urandom);
      if (ctl == 4'b0000 && ($urandom_range(0, 1) == 1)) ad[6:4] = 3'd2 | 3'(ad[4]);
      if (ctl == 4'b0000) ad[2] = ad[2] & ad[8];
      step(ctl[3], ctl[2], ctl[1], ctl[0], 2'($urandom_range(0, 3)), ad);
    end

    done = 1'b1;
    report();
  end
endmodule